// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

The block moves 8-bit characters over a three-wire clocked link: a serial clock, a data-out line and a data-in line. Characters carry no start, stop or parity bits. Each one is shifted least significant bit first. The transmitter changes its data line after a falling clock edge. The receiver captures its data line after a rising clock edge. Characters to send wait in a small transmit FIFO. Received characters collect in a receive FIFO, and a programmable trigger level on that FIFO drives the ready flag.

The serial clock has two sources. In internal mode a divider from the system clock produces bursts of exactly eight pulses per character, and the burst drives the clock pin. In external mode the block follows a clock pin input. It synchronizes that input and acts on the detected edges. The block starts an internal burst when the transmitter is enabled and holds data. With only the receiver enabled, it starts a burst whenever the receive FIFO holds fewer characters than the trigger level.

Top module: `sync_serial_xcvr`

## Requirements
- R1: In internal mode, each character produces exactly 8 falling and 8 rising edges on `sck_out`. `sdo` changes only while `sck_out` is low. Bits leave least significant first, so the values of `sdo` at the eight rising edges are bits 0 to 7 in turn.
- R2: `sck_out` is 1 after reset, between characters, and at all times while `clk_sel_ext` is 1.
- R3: `sdo` is 1 after reset. After a character it keeps the value of that character's bit 7 until the next character starts.
- R4: The receiver samples `sdi` on each rising serial clock edge and assembles the bits least significant first. Complete characters enter the receive FIFO. They are read in arrival order at `rx_data`, and a one-cycle `rx_rd` pulse removes the oldest.
- R5: In internal mode with `rx_en`=1 and `tx_en`=0, bursts repeat while `rx_count` < `rx_trig`, then stop. `rx_ready` is 1 exactly when `rx_count` >= `rx_trig`.
- R6: The transmit FIFO holds DEPTH characters, and `tx_full` is 1 when it holds DEPTH. Nothing is transmitted while `tx_en`=0. Once `tx_en`=1, the queued characters are sent in write order.
- R7: With `clk_sel_ext`=1, a falling edge on `sck_in` shifts transmit data and a rising edge on `sck_in` samples receive data, under the same bit order as in internal mode.
- R8: If a character completes while the receive FIFO is full, that character is dropped and `overrun` is set. `overrun` stays 1 until an `overrun_clr` pulse clears it.
- R9: Setting `rx_en` to 0 leaves `rx_count`, `rx_data` and `overrun` unchanged, and discards any partly received character.
- R10: Setting `tx_en` to 0 abandons a partly sent character. The next character begins again at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| clk_sel_ext | input | 1 | 1 selects the external clock on sck_in, 0 selects the internal divider |
| baud_div | input | DIVW | Half-period of the internal clock minus one, in system cycles (at least 1) |
| rx_trig | input | CW | Receive FIFO trigger level (1 to DEPTH) |
| tx_wr | input | 1 | Write strobe for the transmit FIFO |
| tx_data | input | 8 | Character to queue for transmission |
| tx_full | output | 1 | Transmit FIFO full |
| rx_rd | input | 1 | Pop strobe for the receive FIFO |
| rx_data | output | 8 | Oldest received character |
| rx_count | output | CW | Number of characters in the receive FIFO |
| rx_ready | output | 1 | Receive FIFO at or above the trigger level |
| overrun | output | 1 | Sticky overrun flag |
| overrun_clr | input | 1 | Write-one-to-clear for overrun |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internal serial clock output |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The checker assumes the following about the inputs:
- `baud_div` is at least 1, so the data line settles while the clock is low.
- `clk_sel_ext` changes only while no character is in flight.
- `tx_wr` is never pulsed while `tx_full` is 1, and `rx_rd` is never pulsed on an empty receive FIFO.

The bench keeps within these limits:
- It uses a divider of 2 and switches the clock source only between tests, after the link has gone quiet.
- It never writes more than DEPTH characters ahead of transmission.
- It pops only after it has seen a nonzero `rx_count`.
- It holds each level of `sck_in` for six system cycles, which is longer than the synchronizer and strobe latency.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int CHAR_BITS = 8;
  typedef logic [CHAR_BITS-1:0] char_t;
endpackage

// File: rtl/sst_fifo.sv
module sst_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [W-1:0]  din,
  input  logic          rd,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (wr && !full) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr && !full)  wptr <= wptr + 1'b1;
      if (rd && !empty) rptr <= rptr + 1'b1;
      case ({wr && !full, rd && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/sst_clkgen.sv
module sst_clkgen #(
  parameter int DIVW = 8,
  parameter int CHAR_BITS = 8,
  localparam int PW = $clog2(CHAR_BITS) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_mode,
  input  logic            req,
  input  logic [DIVW-1:0] div,
  input  logic            sck_in,
  output logic            sck_out,
  output logic            fall_stb,
  output logic            rise_stb
);
  logic            active, sck_r, fall_i, rise_i, fall_e, rise_e;
  logic [DIVW-1:0] hcnt;
  logic [PW-1:0]   pcnt;
  logic [1:0]      hold;
  logic [2:0]      sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      sck_r  <= 1'b1;
      hcnt   <= '0;
      pcnt   <= '0;
      hold   <= '0;
      fall_i <= 1'b0;
      rise_i <= 1'b0;
    end else begin
      fall_i <= 1'b0;
      rise_i <= 1'b0;
      if (ext_mode) begin
        active <= 1'b0;
        sck_r  <= 1'b1;
        hcnt   <= '0;
        pcnt   <= '0;
      end else if (!active) begin
        if (hold != 2'd0) hold <= hold - 2'd1;
        else if (req) begin
          active <= 1'b1;
          hcnt   <= '0;
          pcnt   <= '0;
        end
      end else if (hcnt == div) begin
        hcnt  <= '0;
        sck_r <= ~sck_r;
        if (sck_r) fall_i <= 1'b1;
        else begin
          rise_i <= 1'b1;
          pcnt   <= pcnt + 1'b1;
          if (pcnt == PW'(CHAR_BITS - 1)) begin
            active <= 1'b0;
            hold   <= 2'd3;
          end
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  // external clock: two-flop synchronizer plus one stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      sync   <= 3'b111;
      fall_e <= 1'b0;
      rise_e <= 1'b0;
    end else begin
      sync   <= {sync[1:0], sck_in};
      fall_e <= sync[2] & ~sync[1];
      rise_e <= ~sync[2] & sync[1];
    end
  end

  assign sck_out  = sck_r;
  assign fall_stb = ext_mode ? fall_e : fall_i;
  assign rise_stb = ext_mode ? rise_e : rise_i;
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import sst_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DIVW  = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int BW   = $clog2(CHAR_BITS) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_en,
  input  logic            rx_en,
  input  logic            clk_sel_ext,
  input  logic [DIVW-1:0] baud_div,
  input  logic [CW-1:0]   rx_trig,
  input  logic            tx_wr,
  input  logic [7:0]      tx_data,
  output logic            tx_full,
  input  logic            rx_rd,
  output logic [7:0]      rx_data,
  output logic [CW-1:0]   rx_count,
  output logic            rx_ready,
  output logic            overrun,
  input  logic            overrun_clr,
  input  logic            sck_in,
  output logic            sck_out,
  output logic            sdo,
  input  logic            sdi
);
  logic          fall_stb, rise_stb, burst_req;
  logic          txf_empty, txf_pop, rxf_full, rxf_empty, rx_done;
  char_t         txf_dout;
  logic [CW-1:0] txf_count;
  logic [BW-1:0] tcnt, rcnt;
  char_t         tsh, rsh;
  char_t         rx_char;

  assign burst_req = (tx_en && !txf_empty) ||
                     (rx_en && !tx_en && (rx_count < rx_trig));

  sst_clkgen #(.DIVW(DIVW), .CHAR_BITS(CHAR_BITS)) u_clk (
    .clk(clk), .rst(rst), .ext_mode(clk_sel_ext), .req(burst_req),
    .div(baud_div), .sck_in(sck_in), .sck_out(sck_out),
    .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  sst_fifo #(.W(CHAR_BITS), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst(rst), .wr(tx_wr), .din(tx_data), .rd(txf_pop),
    .dout(txf_dout), .count(txf_count), .full(tx_full), .empty(txf_empty)
  );

  // transmitter: loads on the first falling edge, shifts on the next seven
  assign txf_pop = tx_en && fall_stb && (tcnt == '0) && !txf_empty;

  always_ff @(posedge clk) begin
    if (rst) sdo <= 1'b1;
    else if (txf_pop) sdo <= txf_dout[0];
    else if (tx_en && fall_stb && tcnt != '0 && tcnt < BW'(CHAR_BITS)) sdo <= tsh[0];
  end

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      tcnt <= '0;
      tsh  <= '0;
    end else if (fall_stb) begin
      if (txf_pop) begin
        tsh  <= txf_dout >> 1;
        tcnt <= BW'(1);
      end else if (tcnt != '0 && tcnt < BW'(CHAR_BITS)) begin
        tsh  <= tsh >> 1;
        tcnt <= tcnt + 1'b1;
      end
    end else if (rise_stb && tcnt == BW'(CHAR_BITS)) begin
      tcnt <= '0;
    end
  end

  // receiver: samples on rising edges, least significant bit first
  assign rx_done = rx_en && rise_stb && (rcnt == BW'(CHAR_BITS - 1));
  assign rx_char = {sdi, rsh[CHAR_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (rst) rsh <= '0;
    else if (rx_en && rise_stb) rsh <= rx_char;
  end

  always_ff @(posedge clk) begin
    if (rst || !rx_en) rcnt <= '0;
    else if (rise_stb) rcnt <= rx_done ? '0 : rcnt + 1'b1;
  end

  sst_fifo #(.W(CHAR_BITS), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst(rst), .wr(rx_done), .din(rx_char), .rd(rx_rd),
    .dout(rx_data), .count(rx_count), .full(rxf_full), .empty(rxf_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) overrun <= 1'b0;
    else if (rx_done && rxf_full) overrun <= 1'b1;
    else if (overrun_clr) overrun <= 1'b0;
  end

  assign rx_ready = (rx_count >= rx_trig);
endmodule

// File: rtl/sst_checker.sv
module sst_checker #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_sel_ext,
  input logic          rx_en,
  input logic          rx_rd,
  input logic [CW-1:0] rx_count,
  input logic          overrun,
  input logic          overrun_clr,
  input logic          sck_out,
  input logic          sdo
);
  // R2
  ext_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
    clk_sel_ext && $past(clk_sel_ext) |-> sck_out);

  // R1
  sdo_quiet_high_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_sel_ext && $past(!clk_sel_ext) && sck_out && $past(sck_out) && !$past(rst) |-> $stable(sdo));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun && !overrun_clr |=> overrun);

  // R8
  overrun_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rx_count) == CW'(DEPTH));

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en && !rx_rd |=> $stable(rx_count));

  // R4
  rx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rx_count <= CW'(DEPTH));
endmodule

bind sync_serial_xcvr sst_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .clk_sel_ext(clk_sel_ext), .rx_en(rx_en),
  .rx_rd(rx_rd), .rx_count(rx_count), .overrun(overrun),
  .overrun_clr(overrun_clr), .sck_out(sck_out), .sdo(sdo)
);

// File: tb/sim_sync_serial_xcvr.sv
`timescale 1ns/1ps
module sim_sync_serial_xcvr;
  localparam int DEPTH = 4;
  localparam int DIVW  = 8;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam logic [7:0] VEC [4] = '{8'hA5, 8'h3C, 8'h01, 8'h80};

  logic clk = 1'b0, rst = 1'b1;
  logic tx_en = 0, rx_en = 0, clk_sel_ext = 0;
  logic [DIVW-1:0] baud_div = 8'd2;
  logic [CW-1:0] rx_trig = CW'(1);
  logic tx_wr = 0, rx_rd = 0, overrun_clr = 0, sck_in = 1;
  logic [7:0] tx_data = 0;
  logic tx_full, rx_ready, overrun, sck_out, sdo, sdi;
  logic [7:0] rx_data;
  logic [CW-1:0] rx_count;
  logic loop = 0, sdi_ext = 0;
  int total = 0, bad = 0, falls = 0;
  logic [7:0] cap = 0;

  assign sdi = loop ? sdo : sdi_ext;
  always #4 clk = ~clk;

  sync_serial_xcvr #(.DEPTH(DEPTH), .DIVW(DIVW)) u0 (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .clk_sel_ext(clk_sel_ext),
    .baud_div(baud_div), .rx_trig(rx_trig), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_full(tx_full), .rx_rd(rx_rd), .rx_data(rx_data), .rx_count(rx_count),
    .rx_ready(rx_ready), .overrun(overrun), .overrun_clr(overrun_clr),
    .sck_in(sck_in), .sck_out(sck_out), .sdo(sdo), .sdi(sdi)
  );

  always @(negedge sck_out) falls++;
  always @(posedge sck_out) cap = {sdo, cap[7:1]};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic pop();
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  task automatic ext_pulses(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sck_in = 0; sdi_ext = b[i];
      cyc(6);
      sck_in = 1;
      cyc(6);
    end
    cyc(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f0;
    cyc(3); rst = 0; cyc(2);
    // reset state
    chk("R2 reset sck", sck_out, 1);
    chk("R3 reset sdo", sdo, 1);
    chk("R4 reset count", rx_count, 0);
    chk("R8 reset overrun", overrun, 0);
    chk("R6 reset full", tx_full, 0);

    // loopback vectors, internal clock
    loop = 1; tx_en = 1; rx_en = 1;
    for (int v = 0; v < 4; v++) begin
      f0 = falls;
      push(VEC[v]);
      while (rx_count == 0) @(negedge clk);
      cyc(20);
      chk("R4 loop data", rx_data, VEC[v]);
      chk("R1 lsb first bits", cap, VEC[v]);
      chk("R1 pulses per char", falls - f0, 8);
      chk("R3 hold last bit", sdo, VEC[v][7]);
      chk("R2 idle high", sck_out, 1);
      pop();
    end

    // queued characters wait for tx_en, then go in order
    tx_en = 0; rx_en = 0;
    f0 = falls;
    for (int i = 0; i < 4; i++) push(8'h10 + 8'(i));
    cyc(40);
    chk("R6 tx full", tx_full, 1);
    chk("R6 no tx when disabled", falls - f0, 0);
    rx_en = 1; tx_en = 1;
    cyc(500);
    chk("R6 all sent", rx_count, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R6 order", rx_data, 8'h10 + 8'(i));
      pop();
    end

    // receive-only internal bursts up to trigger
    tx_en = 0; loop = 0; sdi_ext = 1; rx_trig = CW'(3);
    f0 = falls;
    cyc(400);
    chk("R5 count at trigger", rx_count, 3);
    chk("R5 pulses", falls - f0, 24);
    chk("R5 ready", rx_ready, 1);
    chk("R4 data ones", rx_data, 8'hFF);
    pop();
    cyc(2);
    chk("R5 ready drops", rx_ready, 0);
    cyc(200);
    chk("R5 refill", rx_count, 3);
    chk("R5 pulses after pop", falls - f0, 32);
    for (int i = 0; i < 3; i++) pop();
    rx_en = 0; cyc(10);

    // external clock receive and overrun
    clk_sel_ext = 1; rx_en = 1; rx_trig = CW'(1);
    cyc(10);
    for (int i = 1; i <= 5; i++) ext_pulses(8'(8'h11 * i), 8);
    chk("R7 ext data", rx_data, 8'h11);
    chk("R8 full count", rx_count, 4);
    chk("R8 overrun set", overrun, 1);
    chk("R2 ext sck high", sck_out, 1);
    // partial character then disable receiver
    ext_pulses(8'hFF, 3);
    rx_en = 0; cyc(10);
    chk("R9 count kept", rx_count, 4);
    chk("R9 data kept", rx_data, 8'h11);
    chk("R9 overrun kept", overrun, 1);
    @(negedge clk); overrun_clr = 1; @(negedge clk); overrun_clr = 0;
    chk("R8 overrun cleared", overrun, 0);
    pop();
    chk("R8 oldest kept", rx_data, 8'h22);
    for (int i = 0; i < 3; i++) pop();
    rx_en = 1;
    ext_pulses(8'h96, 8);
    chk("R9 fresh char after disable", rx_data, 8'h96);
    pop();

    // abandon a partial transmit
    loop = 1; rx_en = 0; tx_en = 1;
    push(8'hF0);
    ext_pulses(8'h00, 3);
    tx_en = 0; cyc(4);
    tx_en = 1; rx_en = 1;
    push(8'h3C);
    ext_pulses(8'h00, 8);
    chk("R10 restart count", rx_count, 1);
    chk("R10 restart data", rx_data, 8'h3C);
    chk("R7 ext hold last", sdo, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule